// File: doc/BRIEF.md
# Ethernet Link and Activity Status Indicator Driver

This block drives three active-low indicator outputs for a dual-speed twisted-pair transceiver. One output shows transmit or receive traffic. One shows a qualified 100 Mb/s link. One shows a qualified 10 Mb/s link. Each output is a register that goes low while its condition holds.

The block takes the following inputs, all already sampled into the clock domain:
- a signal-detect level from the 100 Mb/s receive path;
- single-cycle strobes for a normal link pulse, for a valid 10 Mb/s frame, for a link-pulse gap timeout, and for transmit and receive activity.

The analog detection, waveform checks and frame validation sit upstream of the block. The block does the qualification counting and the release timing. The 100 Mb/s indicator needs an unbroken stretch of signal detect before it turns on, and it turns off as soon as signal detect goes away. The 10 Mb/s indicator needs a run of consecutive link pulses or one good frame before it turns on. It stays on until a link-loss interval passes with no pulse and no frame. The activity indicator is stretched so that short bursts stay visible.

Every time interval is a parameter counted in clock cycles. The defaults give about 500 us of qualification, 100 ms of link loss and a 20 ms activity stretch at 125 MHz. A test build can shorten all of them.

Top module: `link_led_status`

## Requirements
- R1: All three outputs are active low: 0 means the indicator is on and 1 means off.
- R2: A tx_act or rx_act strobe sampled at a clock edge drives led_act_n to 0 from that edge.
- R3: After the last activity strobe, led_act_n stays 0 for STRETCH_CYCLES edges in total, counting the strobe edge, and then returns to 1. A new strobe restarts this window.
- R4: led_100_n goes to 0 at the edge where sig_det_100 has been sampled high on QUAL_CYCLES consecutive edges, and not earlier.
- R5: An edge that samples sig_det_100 low drives led_100_n to 1 at that edge and restarts the qualification count from zero.
- R6: led_10_n goes to 0 at the edge that samples the PULSE_COUNT-th consecutive nlp_strobe.
- R7: A gap_timeout strobe clears the consecutive-pulse count. An nlp_strobe on the same edge then counts as the first pulse of a new run.
- R8: One pkt_ok strobe drives led_10_n to 0 at the edge that samples it.
- R9: Each nlp_strobe or pkt_ok strobe restarts a link-loss timer. If LOSS_CYCLES further edges pass with neither strobe, led_10_n returns to 1 at the last of them and the pulse count is cleared.
- R10: A synchronous active-high rst drives all three outputs to 1 and clears every counter. The link-loss timer is left idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_det_100 | input | 1 | 100 Mb/s signal-detect level |
| nlp_strobe | input | 1 | One normal link pulse received |
| pkt_ok | input | 1 | One valid 10 Mb/s frame received |
| gap_timeout | input | 1 | Maximum gap between link pulses exceeded |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| led_act_n | output | 1 | Activity indicator, active low |
| led_100_n | output | 1 | 100 Mb/s link indicator, active low |
| led_10_n | output | 1 | 10 Mb/s link indicator, active low |

## Verification
The bench builds the block with QUAL_CYCLES=4, PULSE_COUNT=7, LOSS_CYCLES=20 and STRETCH_CYCLES=3. These short windows let the bench sweep every run length of signal detect from zero to past the qualification point. They also let it walk every edge of the link-loss interval and of the activity stretch, and check each cycle against a count worked out in the bench. The pulse count keeps its real value of seven, so the sweep passes through each step from the first pulse to the run that brings the link up. It also covers a gap timeout in the middle of a run and a count cleared when the loss timer expires.

// File: rtl/link_led_pkg.sv
package link_led_pkg;

  // Indicator drive levels: outputs are active low.
  localparam logic LED_ON  = 1'b0;
  localparam logic LED_OFF = 1'b1;

  // Width of a counter that must hold values 0..limit inclusive.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/fast_link_qual.sv
module fast_link_qual
  import link_led_pkg::*;
#(
  parameter int QUAL_CYCLES = 62500
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_det,
  output logic led_n
);

  localparam int QW = cnt_width(QUAL_CYCLES);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0] run_q;
  logic [QW-1:0] run_d;

  // Saturating count of consecutive edges with signal detect high.
  always_comb begin
    if (!sig_det)
      run_d = '0;
    else if (run_q == QMAX)
      run_d = QMAX;
    else
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      led_n <= LED_OFF;
    end else begin
      run_q <= run_d;
      led_n <= (run_d == QMAX) ? LED_ON : LED_OFF;
    end
  end

endmodule

// File: rtl/slow_link_qual.sv
module slow_link_qual
  import link_led_pkg::*;
#(
  parameter int PULSE_COUNT = 7,
  parameter int LOSS_CYCLES = 12500000
) (
  input  logic clk,
  input  logic rst,
  input  logic nlp,
  input  logic pkt,
  input  logic gap_timeout,
  output logic led_n
);

  localparam int PW = cnt_width(PULSE_COUNT);
  localparam int TW = cnt_width(LOSS_CYCLES);
  localparam logic [PW-1:0] PMAX = PW'(PULSE_COUNT);
  localparam logic [TW-1:0] TLOAD = TW'(LOSS_CYCLES);
  localparam logic [TW-1:0] TONE = TW'(1);

  logic [PW-1:0] pcnt_q, pcnt_d, pcnt_base;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          link_q, link_d;
  logic          refresh, expire;

  assign link_q  = (led_n == LED_ON);
  assign refresh = nlp || pkt;
  // The timer runs out at this edge: the last strobe was LOSS_CYCLES edges ago.
  assign expire  = !refresh && (tmr_q == TONE);

  always_comb begin
    if (refresh)
      tmr_d = TLOAD;
    else if (tmr_q != '0)
      tmr_d = tmr_q - 1'b1;
    else
      tmr_d = '0;
  end

  always_comb begin
    pcnt_base = (gap_timeout || expire) ? '0 : pcnt_q;
    if (nlp)
      pcnt_d = (pcnt_base == PMAX) ? PMAX : pcnt_base + 1'b1;
    else
      pcnt_d = pcnt_base;
  end

  always_comb begin
    link_d = pkt || (nlp && (pcnt_d == PMAX)) || (link_q && !expire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      tmr_q  <= '0;
      led_n  <= LED_OFF;
    end else begin
      pcnt_q <= pcnt_d;
      tmr_q  <= tmr_d;
      led_n  <= link_d ? LED_ON : LED_OFF;
    end
  end

endmodule

// File: rtl/activity_stretch.sv
module activity_stretch
  import link_led_pkg::*;
#(
  parameter int STRETCH_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  output logic led_n
);

  localparam int SW = cnt_width(STRETCH_CYCLES);
  localparam logic [SW-1:0] SLOAD = SW'(STRETCH_CYCLES);

  logic [SW-1:0] left_q, left_d;

  // Edges still to hold the indicator on, counting the current one.
  always_comb begin
    if (act)
      left_d = SLOAD;
    else if (left_q != '0)
      left_d = left_q - 1'b1;
    else
      left_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      led_n  <= LED_OFF;
    end else begin
      left_q <= left_d;
      led_n  <= (left_d != '0) ? LED_ON : LED_OFF;
    end
  end

endmodule

// File: rtl/link_led_status.sv
module link_led_status
  import link_led_pkg::*;
#(
  parameter int QUAL_CYCLES    = 62500,
  parameter int PULSE_COUNT    = 7,
  parameter int LOSS_CYCLES    = 12500000,
  parameter int STRETCH_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_det_100,
  input  logic nlp_strobe,
  input  logic pkt_ok,
  input  logic gap_timeout,
  input  logic tx_act,
  input  logic rx_act,
  output logic led_act_n,
  output logic led_100_n,
  output logic led_10_n
);

  logic any_act;
  assign any_act = tx_act || rx_act;

  fast_link_qual #(
    .QUAL_CYCLES(QUAL_CYCLES)
  ) u_fast (
    .clk    (clk),
    .rst    (rst),
    .sig_det(sig_det_100),
    .led_n  (led_100_n)
  );

  slow_link_qual #(
    .PULSE_COUNT(PULSE_COUNT),
    .LOSS_CYCLES(LOSS_CYCLES)
  ) u_slow (
    .clk        (clk),
    .rst        (rst),
    .nlp        (nlp_strobe),
    .pkt        (pkt_ok),
    .gap_timeout(gap_timeout),
    .led_n      (led_10_n)
  );

  activity_stretch #(
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) u_act (
    .clk  (clk),
    .rst  (rst),
    .act  (any_act),
    .led_n(led_act_n)
  );

endmodule

// File: rtl/link_led_status_chk.sv
module link_led_status_chk
  import link_led_pkg::*;
#(
  parameter int QUAL_CYCLES    = 62500,
  parameter int LOSS_CYCLES    = 12500000
) (
  input logic clk,
  input logic rst,
  input logic sig_det_100,
  input logic nlp_strobe,
  input logic pkt_ok,
  input logic tx_act,
  input logic rx_act,
  input logic led_act_n,
  input logic led_100_n,
  input logic led_10_n
);

  localparam int QW = cnt_width(QUAL_CYCLES);
  localparam int TW = cnt_width(LOSS_CYCLES);

  logic [QW-1:0] hi_run;
  logic [TW-1:0] quiet;

  // Independent tally of consecutive high samples of signal detect.
  always_ff @(posedge clk) begin
    if (rst)
      hi_run <= '0;
    else if (!sig_det_100)
      hi_run <= '0;
    else if (hi_run != QW'(QUAL_CYCLES))
      hi_run <= hi_run + 1'b1;
  end

  // Edges since the last 10 Mb/s refresh, saturating at the loss limit.
  always_ff @(posedge clk) begin
    if (rst)
      quiet <= TW'(LOSS_CYCLES);
    else if (nlp_strobe || pkt_ok)
      quiet <= '0;
    else if (quiet != TW'(LOSS_CYCLES))
      quiet <= quiet + 1'b1;
  end

  assert_reset_dark_R10: assert property (@(posedge clk)
    rst |=> (led_act_n == LED_OFF && led_100_n == LED_OFF && led_10_n == LED_OFF));

  assert_act_on_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_act || rx_act) |=> (led_act_n == LED_ON));

  assert_fast_qualified_R4: assert property (@(posedge clk) disable iff (rst)
    (led_100_n == LED_ON) |-> (hi_run == QW'(QUAL_CYCLES)));

  assert_fast_drop_R5: assert property (@(posedge clk) disable iff (rst)
    !sig_det_100 |=> (led_100_n == LED_OFF));

  assert_pkt_link_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |=> (led_10_n == LED_ON));

  assert_loss_release_R9: assert property (@(posedge clk) disable iff (rst)
    (quiet == TW'(LOSS_CYCLES)) |-> (led_10_n == LED_OFF));

endmodule

bind link_led_status link_led_status_chk #(
  .QUAL_CYCLES(QUAL_CYCLES),
  .LOSS_CYCLES(LOSS_CYCLES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sig_det_100(sig_det_100),
  .nlp_strobe (nlp_strobe),
  .pkt_ok     (pkt_ok),
  .tx_act     (tx_act),
  .rx_act     (rx_act),
  .led_act_n  (led_act_n),
  .led_100_n  (led_100_n),
  .led_10_n   (led_10_n)
);

// File: tb/link_led_status_bench.sv
`timescale 1ns/1ps
module link_led_status_bench;

  localparam int Q = 4;
  localparam int P = 7;
  localparam int L = 20;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_det_100 = 1'b0;
  logic nlp_strobe = 1'b0;
  logic pkt_ok = 1'b0;
  logic gap_timeout = 1'b0;
  logic tx_act = 1'b0;
  logic rx_act = 1'b0;
  logic led_act_n, led_100_n, led_10_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_led_status #(
    .QUAL_CYCLES(Q), .PULSE_COUNT(P), .LOSS_CYCLES(L), .STRETCH_CYCLES(S)
  ) u_link_led_status (
    .clk(clk), .rst(rst), .sig_det_100(sig_det_100), .nlp_strobe(nlp_strobe),
    .pkt_ok(pkt_ok), .gap_timeout(gap_timeout), .tx_act(tx_act), .rx_act(rx_act),
    .led_act_n(led_act_n), .led_100_n(led_100_n), .led_10_n(led_10_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock edge passes; inputs were set before it, outputs read after it.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sig_det_100 = 1'b0; nlp_strobe = 1'b0; pkt_ok = 1'b0;
    gap_timeout = 1'b0; tx_act = 1'b0; rx_act = 1'b0;
    tick();
    rst = 1'b0;
  endtask

  task automatic pulse_nlp();
    nlp_strobe = 1'b1; tick(); nlp_strobe = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R10 / R1: reset state all off (high)
    chk("R10 act", led_act_n, 1'b1);
    chk("R10 100", led_100_n, 1'b1);
    chk("R10 10", led_10_n, 1'b1);

    // R4/R5: sweep run lengths of signal detect
    for (int k = 0; k <= Q + 2; k++) begin
      for (int i = 0; i < k; i++) begin
        sig_det_100 = 1'b1; tick();
        chk("R4 qualify", led_100_n, ((i + 1) >= Q) ? 1'b0 : 1'b1);
      end
      sig_det_100 = 1'b0; tick();
      chk("R5 drop", led_100_n, 1'b1);
    end
    // R5: interruption one short of qualification restarts count
    for (int i = 0; i < Q - 1; i++) begin sig_det_100 = 1'b1; tick(); end
    sig_det_100 = 1'b0; tick();
    for (int i = 0; i < Q - 1; i++) begin
      sig_det_100 = 1'b1; tick();
      chk("R5 restart", led_100_n, 1'b1);
    end
    tick();
    chk("R5 requalify", led_100_n, 1'b0);
    sig_det_100 = 1'b0; tick();

    // R6: pulse run, gap of 2 cycles between pulses
    do_reset();
    for (int n = 1; n <= P + 1; n++) begin
      pulse_nlp();
      chk("R6 pulses", led_10_n, (n >= P) ? 1'b0 : 1'b1);
      tick(); tick();
    end

    // R7: gap timeout mid-run
    do_reset();
    for (int n = 0; n < P - 1; n++) begin pulse_nlp(); tick(); end
    gap_timeout = 1'b1; tick(); gap_timeout = 1'b0;
    chk("R7 cleared", led_10_n, 1'b1);
    for (int n = 1; n <= P; n++) begin
      pulse_nlp();
      chk("R7 recount", led_10_n, (n >= P) ? 1'b0 : 1'b1);
      tick();
    end
    // R7: timeout together with pulse counts as first
    do_reset();
    for (int n = 0; n < P - 1; n++) begin pulse_nlp(); tick(); end
    gap_timeout = 1'b1; nlp_strobe = 1'b1; tick();
    gap_timeout = 1'b0; nlp_strobe = 1'b0;
    chk("R7 same edge", led_10_n, 1'b1);
    for (int n = 2; n <= P; n++) begin
      pulse_nlp();
      chk("R7 same edge run", led_10_n, (n >= P) ? 1'b0 : 1'b1);
    end

    // R8 + R9: packet then loss window
    do_reset();
    pkt_ok = 1'b1; tick(); pkt_ok = 1'b0;
    chk("R8 packet", led_10_n, 1'b0);
    for (int j = 1; j <= L + 1; j++) begin
      tick();
      chk("R9 loss", led_10_n, (j >= L) ? 1'b1 : 1'b0);
    end
    // R9: pulse refreshes timer
    pkt_ok = 1'b1; tick(); pkt_ok = 1'b0;
    for (int j = 1; j < L - 5; j++) tick();
    pulse_nlp();
    chk("R9 refresh", led_10_n, 1'b0);
    for (int j = 1; j <= L; j++) begin
      tick();
      chk("R9 refreshed loss", led_10_n, (j >= L) ? 1'b1 : 1'b0);
    end
    // R9: expiry clears the pulse count
    do_reset();
    for (int n = 0; n < P - 1; n++) pulse_nlp();
    for (int j = 0; j < L; j++) tick();
    pulse_nlp();
    chk("R9 count cleared", led_10_n, 1'b1);

    // R2/R3: activity stretch
    do_reset();
    tx_act = 1'b1; tick(); tx_act = 1'b0;
    chk("R2 tx", led_act_n, 1'b0);
    for (int j = 1; j <= S + 1; j++) begin
      tick();
      chk("R3 stretch", led_act_n, (j < S) ? 1'b0 : 1'b1);
    end
    rx_act = 1'b1; tick(); rx_act = 1'b0;
    chk("R2 rx", led_act_n, 1'b0);
    tick();
    rx_act = 1'b1; tick(); rx_act = 1'b0;
    for (int j = 1; j <= S; j++) begin
      tick();
      chk("R3 retrigger", led_act_n, (j < S) ? 1'b0 : 1'b1);
    end

    // R10: reset while all indicators are on
    sig_det_100 = 1'b1;
    for (int i = 0; i < Q; i++) tick();
    pkt_ok = 1'b1; tx_act = 1'b1; tick();
    pkt_ok = 1'b0; tx_act = 1'b0;
    chk("R1 all on act", led_act_n, 1'b0);
    chk("R1 all on 100", led_100_n, 1'b0);
    chk("R1 all on 10", led_10_n, 1'b0);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R10 act mid", led_act_n, 1'b1);
    chk("R10 100 mid", led_100_n, 1'b1);
    chk("R10 10 mid", led_10_n, 1'b1);
    sig_det_100 = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule